// File: doc/BRIEF.md
# Warp Memory Access Coalescer

The coalescer takes one memory request issued on behalf of a whole warp and turns it into the shortest list of aligned line transactions that covers every active thread. A request carries one byte address per lane, a per-lane active mask, an access width of 4, 8 or 16 bytes, and a line-mode select. Active lanes are grouped by the aligned line their accessed bytes fall in. The block emits one transaction per distinct line, carrying the line base address and the set of lanes that line serves.

Transactions leave one per cycle over a valid/ready handshake. The block takes a new request only after the downstream has accepted the final transaction of the previous one. A request whose mask is all zero is taken and produces no transactions. The wide line mode uses 128-byte lines. The narrow mode uses 32-byte lines, which suits data that lives only in the second-level cache.

Top module: `warp_coalescer`

## Requirements
- R1: After reset, `req_ready` is 1 and `txn_valid` is 0.
- R2: In wide mode, 32 active lanes that read consecutive 4-byte words starting at a 128-byte aligned address give exactly one transaction whose lane mask is all ones.
- R3: Exactly one transaction is emitted for each distinct line touched by the active lanes. Its `txn_base` is the line address with the low log2(line size) bits zero.
- R4: `req_size` encodes the access width: 0 is 4 bytes, 1 is 8 bytes, 2 is 16 bytes, and 3 is also treated as 16 bytes. A lane touches bytes addr through addr+width-1.
- R5: `req_narrow` = 0 selects 128-byte lines and `req_narrow` = 1 selects 32-byte lines. The mode is captured together with the request.
- R6: A lane whose `req_mask` bit is 0 contributes no line and no mask bit. An all-zero mask yields no transaction, and `req_ready` stays 1.
- R7: Transactions are ordered by the lowest lane that touches each line. Within one lane, the lower line comes first.
- R8: Bit i of `txn_lanes` is 1 exactly when lane i is active and touches that transaction's line. Lane i is the address at bits [32*i+31 : 32*i] of `req_addr`.
- R9: An access that straddles a line boundary sets its lane's bit in the transactions for both lines.
- R10: `req_ready` falls in the cycle after a request with a nonzero mask is accepted. It rises in the cycle after the handshake of that request's last transaction.
- R11: While `txn_valid` is 1 and `txn_ready` is 0, `txn_valid`, `txn_base` and `txn_lanes` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Warp request offered |
| req_ready | output | 1 | Block can take a request |
| req_addr | input | LANES*ADDR_W | Per-lane byte addresses, lane 0 in the low bits |
| req_mask | input | LANES | Active-lane mask |
| req_size | input | 2 | Access width code |
| req_narrow | input | 1 | 1 selects 32-byte lines, 0 selects 128-byte lines |
| txn_valid | output | 1 | Transaction offered |
| txn_ready | input | 1 | Downstream takes the transaction |
| txn_base | output | ADDR_W | Aligned line base address |
| txn_lanes | output | LANES | Lanes served by this transaction |

## Verification
The bench builds the block with its defaults: 32 lanes, 32-bit addresses, and line sizes of 128 and 32 bytes. At these values the full warp width and both line modes can be tested. They also allow 16-byte accesses that straddle a 32-byte line, so one lane appears in two transactions. Directed requests cover the single-transaction case, wider accesses, scattered and reversed strides, partial and empty masks, and a request held back while another drains. Random requests then run under random downstream back-pressure.

// File: rtl/coal_pkg.sv
package coal_pkg;

    // Access width codes carried on req_size
    typedef enum logic [1:0] {
        ACC_4B   = 2'd0,
        ACC_8B   = 2'd1,
        ACC_16B  = 2'd2,
        ACC_16BX = 2'd3
    } acc_size_e;

    // Line granularity select
    typedef enum logic {
        LINE_WIDE   = 1'b0,
        LINE_NARROW = 1'b1
    } line_mode_e;

    // Number of bytes one lane touches for a given width code
    function automatic int unsigned span_bytes(acc_size_e s);
        case (s)
            ACC_4B:  return 4;
            ACC_8B:  return 8;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/coal_lane_span.sv
module coal_lane_span
    import coal_pkg::*;
#(
    parameter int ADDR_W    = 32,
    parameter int WIDE_SH   = 7,
    parameter int NARROW_SH = 5
) (
    input  logic [ADDR_W-1:0] addr,
    input  acc_size_e         size,
    input  line_mode_e        mode,
    output logic [ADDR_W-1:0] lo_line,
    output logic [ADDR_W-1:0] hi_line,
    output logic              crosses
);
    logic [ADDR_W-1:0] last_byte;

    always_comb begin
        last_byte = addr + ADDR_W'(span_bytes(size) - 1);
        if (mode == LINE_NARROW) begin
            lo_line = addr >> NARROW_SH;
            hi_line = last_byte >> NARROW_SH;
        end else begin
            lo_line = addr >> WIDE_SH;
            hi_line = last_byte >> WIDE_SH;
        end
        crosses = (lo_line != hi_line);
    end
endmodule

// File: rtl/coal_first_pick.sv
module coal_first_pick #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic [LANES-1:0]              pend_lo,
    input  logic [LANES-1:0]              pend_hi,
    input  logic [LANES-1:0][ADDR_W-1:0]  lo_line,
    input  logic [LANES-1:0][ADDR_W-1:0]  hi_line,
    output logic                          sel_any,
    output logic [ADDR_W-1:0]             sel_line,
    output logic [LANES-1:0]              sel_onehot
);
    // Lowest pending lane wins; its lower line goes before its upper one.
    always_comb begin
        sel_any    = 1'b0;
        sel_line   = '0;
        sel_onehot = '0;
        for (int i = LANES - 1; i >= 0; i--) begin
            if (pend_lo[i] || pend_hi[i]) begin
                sel_any       = 1'b1;
                sel_onehot    = '0;
                sel_onehot[i] = 1'b1;
                sel_line      = pend_lo[i] ? lo_line[i] : hi_line[i];
            end
        end
    end

    // R7
    single_leader_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_onehot) && (sel_any == (|(pend_lo | pend_hi))));
endmodule

// File: rtl/coal_line_match.sv
module coal_line_match #(
    parameter int LANES  = 32,
    parameter int ADDR_W = 32
) (
    input  logic [LANES-1:0]              pend_lo,
    input  logic [LANES-1:0]              pend_hi,
    input  logic [LANES-1:0][ADDR_W-1:0]  lo_line,
    input  logic [LANES-1:0][ADDR_W-1:0]  hi_line,
    input  logic [ADDR_W-1:0]             sel_line,
    output logic [LANES-1:0]              hit_lo,
    output logic [LANES-1:0]              hit_hi
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign hit_lo[g] = pend_lo[g] && (lo_line[g] == sel_line);
        assign hit_hi[g] = pend_hi[g] && (hi_line[g] == sel_line);
    end
endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
    import coal_pkg::*;
#(
    parameter int LANES         = 32,
    parameter int ADDR_W        = 32,
    parameter int WIDE_LINE_B   = 128,
    parameter int NARROW_LINE_B = 32
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      req_valid,
    output logic                      req_ready,
    input  logic [LANES*ADDR_W-1:0]   req_addr,
    input  logic [LANES-1:0]          req_mask,
    input  logic [1:0]                req_size,
    input  logic                      req_narrow,
    output logic                      txn_valid,
    input  logic                      txn_ready,
    output logic [ADDR_W-1:0]         txn_base,
    output logic [LANES-1:0]          txn_lanes
);
    localparam int WIDE_SH   = $clog2(WIDE_LINE_B);
    localparam int NARROW_SH = $clog2(NARROW_LINE_B);

    // Captured request
    logic [LANES-1:0][ADDR_W-1:0] addr_q;
    logic [LANES-1:0]             mask_q;
    acc_size_e                    size_q;
    line_mode_e                   mode_q;

    // Per-lane work still owed: lower line and (if straddling) upper line
    logic [LANES-1:0] pend_lo;
    logic [LANES-1:0] pend_hi;
    logic [LANES-1:0] pend_hi_eff;

    logic [LANES-1:0][ADDR_W-1:0] lo_line;
    logic [LANES-1:0][ADDR_W-1:0] hi_line;
    logic [LANES-1:0]             crosses;

    logic                sel_any;
    logic [ADDR_W-1:0]   sel_line;
    logic [LANES-1:0]    sel_onehot;
    logic [LANES-1:0]    hit_lo;
    logic [LANES-1:0]    hit_hi;

    logic accept;
    logic fire;

    for (genvar g = 0; g < LANES; g++) begin : g_span
        coal_lane_span #(
            .ADDR_W    (ADDR_W),
            .WIDE_SH   (WIDE_SH),
            .NARROW_SH (NARROW_SH)
        ) u_span (
            .addr    (addr_q[g]),
            .size    (size_q),
            .mode    (mode_q),
            .lo_line (lo_line[g]),
            .hi_line (hi_line[g]),
            .crosses (crosses[g])
        );
    end

    assign pend_hi_eff = pend_hi & crosses;

    coal_first_pick #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_pick (
        .clk        (clk),
        .rst        (rst),
        .pend_lo    (pend_lo),
        .pend_hi    (pend_hi_eff),
        .lo_line    (lo_line),
        .hi_line    (hi_line),
        .sel_any    (sel_any),
        .sel_line   (sel_line),
        .sel_onehot (sel_onehot)
    );

    coal_line_match #(
        .LANES  (LANES),
        .ADDR_W (ADDR_W)
    ) u_match (
        .pend_lo  (pend_lo),
        .pend_hi  (pend_hi_eff),
        .lo_line  (lo_line),
        .hi_line  (hi_line),
        .sel_line (sel_line),
        .hit_lo   (hit_lo),
        .hit_hi   (hit_hi)
    );

    assign txn_valid = sel_any;
    assign req_ready = !sel_any;
    assign txn_lanes = hit_lo | hit_hi;
    assign txn_base  = (mode_q == LINE_NARROW) ? (sel_line << NARROW_SH)
                                                : (sel_line << WIDE_SH);

    assign accept = req_valid && req_ready;
    assign fire   = txn_valid && txn_ready;

    always_ff @(posedge clk) begin
        if (rst) begin
            addr_q  <= '0;
            mask_q  <= '0;
            size_q  <= ACC_4B;
            mode_q  <= LINE_WIDE;
            pend_lo <= '0;
            pend_hi <= '0;
        end else if (accept) begin
            for (int i = 0; i < LANES; i++) begin
                addr_q[i] <= req_addr[i*ADDR_W +: ADDR_W];
            end
            mask_q  <= req_mask;
            size_q  <= acc_size_e'(req_size);
            mode_q  <= line_mode_e'(req_narrow);
            pend_lo <= req_mask;
            pend_hi <= req_mask;
        end else if (fire) begin
            pend_lo <= pend_lo & ~hit_lo;
            pend_hi <= pend_hi & ~hit_hi;
        end
    end

    // R11
    txn_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_valid && !txn_ready) |=> (txn_valid && $stable(txn_base) && $stable(txn_lanes)));

    // R10
    start_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && (|req_mask)) |=> txn_valid);

    // R6
    empty_req_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !(|req_mask)) |=> req_ready);

    // R3
    distinct_line_chk: assert property (@(posedge clk) disable iff (rst)
        fire |=> (!txn_valid || (txn_base != $past(txn_base))));

    // R8
    lanes_in_mask_chk: assert property (@(posedge clk) disable iff (rst)
        txn_valid |-> ((txn_lanes != '0) && ((txn_lanes & ~mask_q) == '0)));
endmodule

// File: tb/tb_warp_coalescer.sv
module tb_warp_coalescer;
    localparam int LANES  = 32;
    localparam int ADDR_W = 32;
    localparam int CYCLE_LIMIT = 150000;

    typedef struct {
        logic [31:0] base;
        logic [31:0] lanes;
    } txn_t;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    req_valid = 1'b0;
    logic                    req_ready;
    logic [LANES*ADDR_W-1:0] req_addr = '0;
    logic [LANES-1:0]        req_mask = '0;
    logic [1:0]              req_size = '0;
    logic                    req_narrow = 1'b0;
    logic                    txn_valid;
    logic                    txn_ready = 1'b0;
    logic [ADDR_W-1:0]       txn_base;
    logic [LANES-1:0]        txn_lanes;

    warp_coalescer dut (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_mask(req_mask),
        .req_size(req_size), .req_narrow(req_narrow),
        .txn_valid(txn_valid), .txn_ready(txn_ready),
        .txn_base(txn_base), .txn_lanes(txn_lanes)
    );

    always #5 clk = ~clk;

    int          vectors = 0;
    int          fails   = 0;
    int          cycles  = 0;
    bit          timed_out = 1'b0;
    bit          want_req  = 1'b0;
    bit          accepted  = 1'b0;
    int          stall_pct = 0;
    int          taken     = 0;
    logic [31:0] st_addr [LANES];
    logic [31:0] st_mask;
    logic [1:0]  st_size;
    logic        st_narrow;
    txn_t        exp_q[$];

    function automatic void build_expect();
        logic [31:0] lines[$];
        int nbytes;
        int sh;
        logic [31:0] lo;
        logic [31:0] hi;
        bit seen;
        nbytes = (st_size == 2'd0) ? 4 : (st_size == 2'd1) ? 8 : 16;
        sh = st_narrow ? 5 : 7;
        for (int l = 0; l < LANES; l++) begin
            if (st_mask[l]) begin
                lo = st_addr[l] >> sh;
                hi = (st_addr[l] + 32'(nbytes - 1)) >> sh;
                seen = 1'b0;
                foreach (lines[k]) if (lines[k] == lo) seen = 1'b1;
                if (!seen) lines.push_back(lo);
                seen = 1'b0;
                foreach (lines[k]) if (lines[k] == hi) seen = 1'b1;
                if (!seen) lines.push_back(hi);
            end
        end
        foreach (lines[k]) begin
            txn_t t;
            t.base  = lines[k] << sh;
            t.lanes = '0;
            for (int l = 0; l < LANES; l++) begin
                if (st_mask[l]) begin
                    lo = st_addr[l] >> sh;
                    hi = (st_addr[l] + 32'(nbytes - 1)) >> sh;
                    if (lo == lines[k] || hi == lines[k]) t.lanes[l] = 1'b1;
                end
            end
            exp_q.push_back(t);
        end
    endfunction

    task automatic check_outputs();
        bit exp_v;
        vectors++;
        exp_v = (exp_q.size() != 0);
        if (txn_valid !== exp_v) begin
            fails++;
            $display("FAIL R7 txn_valid: got %0b expected %0b", txn_valid, exp_v);
        end else if (exp_v) begin
            if (txn_base !== exp_q[0].base) begin
                fails++;
                $display("FAIL R3 R11 txn_base: got %h expected %h", txn_base, exp_q[0].base);
            end
            if (txn_lanes !== exp_q[0].lanes) begin
                fails++;
                $display("FAIL R8 txn_lanes: got %h expected %h", txn_lanes, exp_q[0].lanes);
            end
        end
        if (req_ready !== !exp_v) begin
            fails++;
            $display("FAIL R10 req_ready: got %0b expected %0b", req_ready, !exp_v);
        end
    endtask

    // One cycle: check at the falling edge, then drive, then advance the model
    task automatic tick();
        @(negedge clk);
        cycles++;
        if (cycles > CYCLE_LIMIT) timed_out = 1'b1;
        check_outputs();
        txn_ready = ($urandom_range(99) >= stall_pct);
        req_valid = want_req;
        if (want_req) begin
            for (int l = 0; l < LANES; l++) req_addr[l*ADDR_W +: ADDR_W] = st_addr[l];
            req_mask   = st_mask;
            req_size   = st_size;
            req_narrow = st_narrow;
        end
        if (txn_valid && txn_ready && exp_q.size() != 0) begin
            void'(exp_q.pop_front());
            taken++;
        end
        if (req_valid && req_ready) begin
            build_expect();
            want_req = 1'b0;
            accepted = 1'b1;
            taken    = 0;
        end
    endtask

    task automatic offer();
        accepted = 1'b0;
        want_req = 1'b1;
        while (!accepted && !timed_out) tick();
    endtask

    task automatic drain();
        while (exp_q.size() != 0 && !timed_out) tick();
        tick();
    endtask

    task automatic send(int exp_cnt, string tag);
        offer();
        drain();
        if (exp_cnt >= 0) begin
            vectors++;
            if (taken != exp_cnt) begin
                fails++;
                $display("FAIL %s transaction count: got %0d expected %0d", tag, taken, exp_cnt);
            end
        end
    endtask

    task automatic fill(logic [31:0] start, int stride);
        for (int l = 0; l < LANES; l++) st_addr[l] = start + 32'(l * stride);
    endtask

    initial begin
        fill(32'h0, 4);
        st_mask = '1; st_size = 2'd0; st_narrow = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        @(negedge clk);
        vectors++;
        if (req_ready !== 1'b1 || txn_valid !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset: got ready=%0b valid=%0b expected ready=1 valid=0", req_ready, txn_valid);
        end

        // R2 consecutive aligned words
        fill(32'h1000, 4); st_mask = '1; st_size = 2'd0; st_narrow = 1'b0;
        send(1, "R2");
        // R4 8-byte and 16-byte widths
        fill(32'h1000, 8); st_size = 2'd1;
        send(2, "R4");
        fill(32'h1000, 16); st_size = 2'd2;
        send(4, "R4");
        st_size = 2'd3;
        send(4, "R4");
        // R3 one line per lane
        fill(32'h8000, 128); st_size = 2'd0;
        send(32, "R3");
        // R7 reversed stride, lane order decides
        for (int l = 0; l < LANES; l++) st_addr[l] = 32'h4000 + 32'((31 - l) * 128);
        send(32, "R7");
        // R6 partial and empty masks
        fill(32'h1000, 4); st_mask = 32'h5555_5555;
        send(1, "R6");
        st_mask = '0;
        send(0, "R6");
        // R5 narrow lines
        st_mask = '1; st_narrow = 1'b1;
        send(4, "R5");
        // R9 straddling 16-byte accesses in narrow mode
        fill(32'h3008, 16); st_size = 2'd2;
        send(17, "R9");
        // R9 straddling word in wide mode
        fill(32'h5002, 4); st_size = 2'd0; st_narrow = 1'b0;
        send(2, "R9");

        // R10 a second request waits while the first drains under stalls
        stall_pct = 50;
        fill(32'h9000, 128); st_mask = '1;
        offer();
        fill(32'hA000, 4);
        offer();
        drain();
        vectors++;
        if (taken != 1) begin
            fails++;
            $display("FAIL R10 held request count: got %0d expected 1", taken);
        end

        // Random requests with back-pressure (R3 R7 R8 R9 R11)
        for (int n = 0; n < 60 && !timed_out; n++) begin
            for (int l = 0; l < LANES; l++)
                st_addr[l] = 32'h2_0000 + $urandom_range(1023);
            st_mask   = $urandom;
            if ($urandom_range(3) == 0) st_mask = '1;
            st_size   = 2'($urandom_range(3));
            st_narrow = 1'($urandom_range(1));
            stall_pct = $urandom_range(70);
            send(-1, "R3");
        end

        if (timed_out) begin
            fails++;
            $display("FAIL watchdog: got %0d cycles expected at most %0d", cycles, CYCLE_LIMIT);
        end
        $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule